// File: doc/BRIEF.md
# Parallel Printer Port Controller

This block connects a CPU register bus to a parallel printer port. The CPU writes a byte into a data register, and that register drives the eight printer data lines. A control register has two request bits that pull the autofeed and initialize lines low, and one bit that enables the interrupt output. A status register returns the printer's busy, acknowledge and error levels, together with a pending-interrupt flag. That flag is set when the acknowledge line rises from low to high at the end of a transfer.

The block leaves the physical pads to the chip level. Every three-state or open-drain pin comes out as a value plus an enable:
- The data lines come out as `pd_out` and `pd_oe`.
- The interrupt comes out as `irq` and `irq_oe`.
- The open-drain lines come out as pull-low requests.

An external active-low output-enable pin decides whether the data lines are driven. When they are released, a read of the data register returns the level the pad reports on `pd_in`. All three printer status inputs pass through two-flop synchronizers before they are used.

Top module: `lpt_port`

## Requirements
- R1: After reset, the data and control registers are zero. This means `pd_out` is 0, `feed_pull`, `init_pull` and `irq_oe` are 0, and `irq` is 0.
- R2: A write to address 0 loads `wdata` into the data register, which appears on `pd_out` after that clock edge. `pd_oe` is high exactly when `lpt_oe_n` is low.
- R3: A read of address 0 returns the data register while `lpt_oe_n` is low, and returns `pd_in` while `lpt_oe_n` is high.
- R4: A write to address 2 loads the control register, and a read of address 2 returns it. Control bit 1 set drives `feed_pull` high (pull autofeed low). Control bit 2 set drives `init_pull` high (pull initialize low).
- R5: `irq_oe` equals control bit 4. When it is low, the interrupt pin is to be left high impedance.
- R6: A read of address 1 returns status with these bits:
  - bit 7: busy
  - bit 6: acknowledge level
  - bit 3: error level
  - bit 2: pending interrupt
  - all other bits: 0

  A change on an input shows up after two clock edges and not after one.
- R7: The pending flag (`irq`) sets on a low-to-high transition of `ack_n`, visible after the third clock edge after the change. Holding `ack_n` low, or holding it high, never sets it.
- R8: A status read clears the pending flag at the clock edge that ends the read. If a new acknowledge rise arrives at that same edge, the flag stays set.
- R9: Access needs `cs_n` low together with `wr_n` low (write) or `rd_n` low (read). Otherwise writes have no effect and `rdata` is 0.
- R10: Addresses 3 to 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Port select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Register address |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | CPU read data, 0 when not reading |
| lpt_oe_n | input | 1 | Data line output enable, active low |
| pd_out | output | 8 | Value for the printer data pads |
| pd_oe | output | 1 | Drive enable for the printer data pads |
| pd_in | input | 8 | Level seen on the printer data pads |
| feed_pull | output | 1 | Pull the autofeed line low |
| init_pull | output | 1 | Pull the initialize line low |
| ack_n | input | 1 | Printer acknowledge, active low |
| busy | input | 1 | Printer busy, high when not ready |
| err_n | input | 1 | Printer error, low during an error |
| irq | output | 1 | Interrupt value, active high |
| irq_oe | output | 1 | Interrupt pad drive enable |

## Verification
The assertions assume that the CPU strobes, address and write data are stable across each clock edge. They also assume that an acknowledge rise is only counted once the synchronizer has seen it, so they make no claim about raw `ack_n` timing. The bench changes every input half a period away from the rising edge. It holds acknowledge pulses for several cycles and keeps the printer inputs fixed during the random register traffic, so that status reads in that phase have a known value.

// File: rtl/lpt_port.sv
module lpt_port #(
  parameter int DW = 8,
  parameter int AW = 3,
  parameter logic [AW-1:0] DATA_ADDR = 3'd0,
  parameter logic [AW-1:0] STAT_ADDR = 3'd1,
  parameter logic [AW-1:0] CTRL_ADDR = 3'd2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          lpt_oe_n,
  output logic [DW-1:0] pd_out,
  output logic          pd_oe,
  input  logic [DW-1:0] pd_in,
  output logic          feed_pull,
  output logic          init_pull,
  input  logic          ack_n,
  input  logic          busy,
  input  logic          err_n,
  output logic          irq,
  output logic          irq_oe
);
  localparam int FEED_BIT = 1;
  localparam int INIT_BIT = 2;
  localparam int IEN_BIT  = 4;
  localparam int ST_PEND  = 2;
  localparam int ST_ERR   = 3;
  localparam int ST_ACK   = 6;
  localparam int ST_BUSY  = 7;

  logic [DW-1:0] data_q, ctrl_q;
  logic [2:0]    ack_q;
  logic [1:0]    busy_q, err_q;
  logic          pend_q;

  wire wr_en   = !cs_n && !wr_n;
  wire rd_en   = !cs_n && !rd_n;
  wire ack_up  = ack_q[1] && !ack_q[2];
  wire st_read = rd_en && (addr == STAT_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= '0;
      ack_q  <= '1;
      busy_q <= '0;
      err_q  <= '1;
      pend_q <= 1'b0;
    end else begin
      if (wr_en && addr == DATA_ADDR) data_q <= wdata;
      if (wr_en && addr == CTRL_ADDR) ctrl_q <= wdata;
      ack_q  <= {ack_q[1:0], ack_n};
      busy_q <= {busy_q[0], busy};
      err_q  <= {err_q[0], err_n};
      pend_q <= ack_up || (pend_q && !st_read);
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        DATA_ADDR: rdata = lpt_oe_n ? pd_in : data_q;
        CTRL_ADDR: rdata = ctrl_q;
        STAT_ADDR: begin
          rdata[ST_BUSY] = busy_q[1];
          rdata[ST_ACK]  = ack_q[1];
          rdata[ST_ERR]  = err_q[1];
          rdata[ST_PEND] = pend_q;
        end
        default: rdata = '0;
      endcase
    end
  end

  assign pd_out    = data_q;
  assign pd_oe     = !lpt_oe_n;
  assign feed_pull = ctrl_q[FEED_BIT];
  assign init_pull = ctrl_q[INIT_BIT];
  assign irq_oe    = ctrl_q[IEN_BIT];
  assign irq       = pend_q;

  // R2
  data_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == DATA_ADDR) |=> pd_out == $past(wdata));

  // R4
  od_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CTRL_ADDR) |=>
      (feed_pull == $past(wdata[FEED_BIT]) && init_pull == $past(wdata[INIT_BIT])));

  // R5
  irq_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CTRL_ADDR) |=> irq_oe == $past(wdata[IEN_BIT]));

  // R7
  rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ack_q[2]);

  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_read && !ack_up) |=> !irq);

  // R9
  no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(pd_out) && $stable(irq_oe) && $stable(feed_pull)));
endmodule

// File: tb/lpt_port_tb.sv
module lpt_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, pd_in = '0;
  logic lpt_oe_n = 1'b0;
  logic ack_n = 1'b1, busy = 1'b0, err_n = 1'b1;
  logic [7:0] rdata, pd_out;
  logic pd_oe, feed_pull, init_pull, irq, irq_oe;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] mdata = '0, mctrl = '0, rv;

  always #2 clk = ~clk;

  lpt_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .lpt_oe_n(lpt_oe_n),
    .pd_out(pd_out), .pd_oe(pd_oe), .pd_in(pd_in),
    .feed_pull(feed_pull), .init_pull(init_pull),
    .ack_n(ack_n), .busy(busy), .err_n(err_n), .irq(irq), .irq_oe(irq_oe)
  );

  function automatic logic [7:0] exp_status(input logic b, input logic a,
                                            input logic e, input logic p);
    logic [7:0] s = '0;
    s[7] = b; s[6] = a; s[3] = e; s[2] = p;
    return s;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic sel, input logic [2:0] a, input logic [7:0] d);
    cs_n = !sel; wr_n = 1'b0; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic cpu_read(input logic sel, input logic [2:0] a, output logic [7:0] d);
    cs_n = !sel; rd_n = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk); @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1 pd_out", pd_out, 0);
    check("R1 pulls/irq_oe", {feed_pull, init_pull, irq_oe, irq}, 0);
    rst_n = 1'b1;
    wait_edges(3);
    check("R1 after release", {pd_out, feed_pull, init_pull, irq_oe, irq}, 0);
    cpu_read(1, 3'd2, rv); check("R1 ctrl readback", rv, 0);

    // R2/R3 directed
    cpu_write(1, 3'd0, 8'hA5); mdata = 8'hA5;
    check("R2 pd_out", pd_out, 8'hA5);
    check("R2 pd_oe low enable", pd_oe, 1);
    lpt_oe_n = 1'b1; pd_in = 8'h3C; #0;
    #1 check("R2 pd_oe released", pd_oe, 0);
    cpu_read(1, 3'd0, rv); check("R3 read pads when released", rv, 8'h3C);
    lpt_oe_n = 1'b0;
    cpu_read(1, 3'd0, rv); check("R3 read register when driven", rv, 8'hA5);

    // R4/R5 directed
    cpu_write(1, 3'd2, 8'h16); mctrl = 8'h16;
    check("R4 feed/init pulls", {feed_pull, init_pull}, 2'b11);
    check("R5 irq_oe on", irq_oe, 1);
    cpu_write(1, 3'd2, 8'h02); mctrl = 8'h02;
    check("R4 feed only", {feed_pull, init_pull}, 2'b10);
    check("R5 irq_oe off", irq_oe, 0);

    // R9/R10 directed
    cpu_write(0, 3'd0, 8'hFF);
    check("R9 unselected write ignored", pd_out, 8'hA5);
    cs_n = 1'b1; rd_n = 1'b0; addr = 3'd2; #1;
    check("R9 rdata zero unselected", rdata, 0);
    rd_n = 1'b1; @(negedge clk);
    cpu_write(1, 3'd5, 8'hFF);
    cpu_read(1, 3'd2, rv); check("R10 ctrl unchanged", rv, mctrl);
    cpu_read(1, 3'd0, rv); check("R10 data unchanged", rv, mdata);
    cpu_read(1, 3'd6, rv); check("R10 unused reads zero", rv, 0);

    // R6 status timing
    busy = 1'b1; err_n = 1'b0;
    wait_edges(1);
    cpu_read(1, 3'd1, rv); check("R6 not yet after one edge", rv, exp_status(0, 1, 1, 0));
    cpu_read(1, 3'd1, rv); check("R6 after two edges", rv, exp_status(1, 1, 0, 0));
    busy = 1'b0; err_n = 1'b1; wait_edges(3);

    // R7 level vs edge
    ack_n = 1'b0; wait_edges(6);
    check("R7 low level does not set", irq, 0);
    cpu_read(1, 3'd1, rv); check("R6 ack level low", rv, exp_status(0, 0, 1, 0));
    ack_n = 1'b1; wait_edges(2);
    check("R7 not before third edge", irq, 0);
    wait_edges(1);
    check("R7 set on rise", irq, 1);
    wait_edges(5);
    check("R7 high level holds once", irq, 1);
    cpu_read(1, 3'd1, rv); check("R8 pending shown", rv, exp_status(0, 1, 1, 1));
    check("R8 cleared by read", irq, 0);

    // R8 simultaneous rise and read
    ack_n = 1'b0; wait_edges(5);
    ack_n = 1'b1; wait_edges(2);
    cpu_read(1, 3'd1, rv); check("R8 read before set", rv[2], 0);
    check("R8 rise wins over clear", irq, 1);
    cpu_read(1, 3'd1, rv); check("R8 second read clears", irq, 0);

    // random register traffic
    for (int i = 0; i < 300; i++) begin
      logic sel; logic [2:0] a; logic [7:0] d; logic [7:0] e;
      sel = ($urandom % 8) != 0;
      a = 3'($urandom % 8);
      d = 8'($urandom);
      lpt_oe_n = 1'($urandom % 2);
      pd_in = 8'($urandom);
      if ($urandom % 2) begin
        cpu_write(sel, a, d);
        if (sel && a == 3'd0) mdata = d;
        if (sel && a == 3'd2) mctrl = d;
        check("R2 random pd_out", pd_out, mdata);
        check("R4 random pulls", {feed_pull, init_pull}, {mctrl[1], mctrl[2]});
        check("R5 random irq_oe", irq_oe, mctrl[4]);
      end else begin
        cpu_read(sel, a, rv);
        if (!sel) e = 8'h00;
        else case (a)
          3'd0: e = lpt_oe_n ? pd_in : mdata;
          3'd1: e = exp_status(0, 1, 1, 0);
          3'd2: e = mctrl;
          default: e = 8'h00;
        endcase
        check("R3/R6/R9/R10 random read", rv, e);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule